// File: doc/BRIEF.md
# Interrupt Dispatch and Destination Resolver

This block sits between a set of interrupt input pins and the message path toward the processors. A separate register block supplies one redirection entry per pin. Each entry holds a mask bit, a vector, a delivery mode, a destination mode, a polarity, a trigger mode and an 8-bit destination. When a pin rises, the block reads that pin's entry and builds one delivery message. It then works out which processors receive the message and gives them as a bit mask with one bit per processor. The message is presented on a valid/ready handshake.

The destination is resolved in one of three ways: physical addressing of a single processor ID, physical broadcast, or logical matching against each processor's logical destination byte. A lowest-priority request in logical mode is narrowed to a single processor by a rotating counter. The counter does not look at any processor priority state. If the delivery mode asks for the vector from an external legacy controller, the block takes that controller's vector input in place of the entry's vector. Assertions that arrive together are served one at a time, lowest pin index first, and wait until the message port is free.

Top module: `irq_dispatch`

## Requirements
- R1: A message is produced only for a low-to-high transition of a pin, seen by comparing the pin with its value at the previous clock edge. A pin that stays high produces nothing more. Lowering a pin only clears its stored level, so the next rise produces a new message.
- R2: If a pin's mask bit is 1 in the cycle the rise is seen, that assertion is discarded and no message is ever sent for it. Clearing the mask later while the pin stays high produces nothing.
- R3: The message vector is the entry's vector field, except when the delivery mode is 3'b111 (external). In that case the vector is `legacy_vec_i`, sampled at the clock edge that loads the message.
- R4: The message copies the entry's delivery mode, its destination-mode bit (1 = logical), its polarity as the level bit, and its trigger bit.
- R5: In physical mode (destination-mode bit 0), destination 8'hFF sets every bit of `msg_targets_o`.
- R6: In physical mode, any other destination d sets only target bit d. If d is not below NUM_CPUS, no message is sent.
- R7: Lowest-priority delivery (mode 3'b001) in physical mode is illegal. It raises `lowpri_err_o` for exactly one cycle, in the cycle a message would have become valid, and sends no message.
- R8: In logical mode, processor i is a target when `cpu_ldr_i[8*i+7:8*i]` AND the destination is non-zero.
- R9: In logical lowest-priority mode with at least one match, the target is the k-th matching processor counted from bit 0 upward, where k is an 8-bit wrapping rotation counter modulo the match count. The counter is reset to 0 and increments after each such message.
- R10: An empty logical target set sends no message and leaves the rotation counter unchanged.
- R11: When several unmasked pins rise in the same cycle, their messages go out one at a time, lowest pin index first. Every pending assertion is held until it is sent.
- R12: A pin seen high at clock edge E gives `msg_valid_o` after edge E+1 if the port is free. While `msg_valid_o` is 1 and `msg_ready_i` is 0, the message holds stable. The next message is loaded at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | NUM_PINS | Interrupt input pins |
| rte_mask_i | input | NUM_PINS | Per-pin mask bit |
| rte_vector_i | input | NUM_PINS*8 | Per-pin vector, pin p at [8p+7:8p] |
| rte_dmode_i | input | NUM_PINS*3 | Per-pin delivery mode, pin p at [3p+2:3p] |
| rte_logical_i | input | NUM_PINS | Per-pin destination mode, 1 = logical |
| rte_polarity_i | input | NUM_PINS | Per-pin polarity |
| rte_trigger_i | input | NUM_PINS | Per-pin trigger mode |
| rte_dest_i | input | NUM_PINS*8 | Per-pin destination, pin p at [8p+7:8p] |
| legacy_vec_i | input | 8 | Vector from the external legacy controller |
| cpu_ldr_i | input | NUM_CPUS*8 | Logical destination byte of each processor |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by the interconnect |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_logical_o | output | 1 | Message destination mode |
| msg_level_o | output | 1 | Message level (entry polarity) |
| msg_trigger_o | output | 1 | Message trigger mode |
| msg_targets_o | output | NUM_CPUS | Target processor mask |
| lowpri_err_o | output | 1 | One-cycle pulse for illegal physical lowest-priority request |

## Verification
A corrupted pending or pin-level bit shows up at the ports within two cycles of the pin event. It appears as a missing message, a duplicate message on a held pin, or messages served in the wrong order when pins rise together. A wrong rotation counter is invisible on any single lowest-priority message. It only shows when a run of consecutive messages walks through the matching processors in the wrong order, or when the walk slips after an empty match set. The tests are therefore built as sequences of messages, not as isolated ones.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWPRI = 3'b001;
    localparam logic [2:0] DM_EXTINT = 3'b111;

    localparam logic [7:0] DEST_ALL  = 8'hFF;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       logical;
        logic       level;
        logic       trigger;
    } msg_hdr_t;

endpackage

// File: rtl/irqd_edge.sv
// Pin level tracking and pending assertion store.
module irqd_edge #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] mask_i,
    input  logic [NUM_PINS-1:0] take_i,
    output logic [NUM_PINS-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] level;
        logic [NUM_PINS-1:0] pend;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [NUM_PINS-1:0] rise;

    always_comb begin
        st_d       = st_q;
        rise       = pin_i & ~st_q.level;
        st_d.level = pin_i;
        // a fresh rise wins over a take of the same bit
        st_d.pend  = (st_q.pend & ~take_i) | (rise & ~mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/irqd_pick.sv
// Lowest-index-first selection among pending pins.
module irqd_pick #(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_PINS-1:0] pend_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqd_resolve.sv
// Destination resolution: physical, broadcast, logical and rotation.
module irqd_resolve
    import irqd_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int ROT_W    = 8
) (
    input  logic                  logical_i,
    input  logic [2:0]            dmode_i,
    input  logic [7:0]            dest_i,
    input  logic [NUM_CPUS*8-1:0] ldr_i,
    input  logic [ROT_W-1:0]      rot_i,
    output logic [NUM_CPUS-1:0]   targets_o,
    output logic                  phys_lp_err_o,
    output logic                  rotate_o
);

    localparam int CNT_W = $clog2(NUM_CPUS + 1);

    logic [NUM_CPUS-1:0] match;
    logic [NUM_CPUS-1:0] phys_sel;
    logic [NUM_CPUS-1:0] lp_sel;
    logic [CNT_W-1:0]    hits;
    logic [ROT_W-1:0]    pick_k;
    logic [ROT_W-1:0]    seen;
    logic                is_lp;

    always_comb begin
        match = '0;
        hits  = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            match[i] = |(ldr_i[i*8 +: 8] & dest_i);
            hits     = hits + CNT_W'(match[i]);
        end
    end

    always_comb begin
        phys_sel = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (dest_i == DEST_ALL || dest_i == 8'(i)) phys_sel[i] = 1'b1;
        end
    end

    assign pick_k = (hits == '0) ? '0 : (rot_i % ROT_W'(hits));

    always_comb begin
        lp_sel = '0;
        seen   = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (match[i]) begin
                if (seen == pick_k) lp_sel[i] = 1'b1;
                seen = seen + 1'b1;
            end
        end
    end

    assign is_lp         = (dmode_i == DM_LOWPRI);
    assign phys_lp_err_o = !logical_i && is_lp;
    assign rotate_o      = logical_i && is_lp && (hits != '0);

    always_comb begin
        if (!logical_i) targets_o = phys_sel;
        else if (is_lp) targets_o = lp_sel;
        else            targets_o = match;
    end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irqd_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_CPUS = 8,
    parameter int ROT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   irq_pin_i,
    input  logic [NUM_PINS-1:0]   rte_mask_i,
    input  logic [NUM_PINS*8-1:0] rte_vector_i,
    input  logic [NUM_PINS*3-1:0] rte_dmode_i,
    input  logic [NUM_PINS-1:0]   rte_logical_i,
    input  logic [NUM_PINS-1:0]   rte_polarity_i,
    input  logic [NUM_PINS-1:0]   rte_trigger_i,
    input  logic [NUM_PINS*8-1:0] rte_dest_i,
    input  logic [7:0]            legacy_vec_i,
    input  logic [NUM_CPUS*8-1:0] cpu_ldr_i,
    output logic                  msg_valid_o,
    input  logic                  msg_ready_i,
    output logic [7:0]            msg_vector_o,
    output logic [2:0]            msg_dmode_o,
    output logic                  msg_logical_o,
    output logic                  msg_level_o,
    output logic                  msg_trigger_o,
    output logic [NUM_CPUS-1:0]   msg_targets_o,
    output logic                  lowpri_err_o
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    typedef struct packed {
        logic                valid;
        logic                err;
        msg_hdr_t            hdr;
        logic [NUM_CPUS-1:0] targets;
        logic [ROT_W-1:0]    rot;
    } disp_state_t;

    disp_state_t st_d, st_q;

    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] take;
    logic                found;
    logic [IDX_W-1:0]    idx;

    logic [7:0]          e_vector;
    logic [2:0]          e_dmode;
    logic                e_logical;
    logic [7:0]          e_dest;
    logic [NUM_CPUS-1:0] res_targets;
    logic                res_err;
    logic                res_rotate;
    logic                load_ok;

    irqd_edge #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (irq_pin_i),
        .mask_i (rte_mask_i),
        .take_i (take),
        .pend_o (pend)
    );

    irqd_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick (
        .pend_i  (pend),
        .found_o (found),
        .idx_o   (idx)
    );

    assign e_vector  = rte_vector_i[idx*8 +: 8];
    assign e_dmode   = rte_dmode_i[idx*3 +: 3];
    assign e_logical = rte_logical_i[idx];
    assign e_dest    = rte_dest_i[idx*8 +: 8];

    irqd_resolve #(.NUM_CPUS(NUM_CPUS), .ROT_W(ROT_W)) u_resolve (
        .logical_i     (e_logical),
        .dmode_i       (e_dmode),
        .dest_i        (e_dest),
        .ldr_i         (cpu_ldr_i),
        .rot_i         (st_q.rot),
        .targets_o     (res_targets),
        .phys_lp_err_o (res_err),
        .rotate_o      (res_rotate)
    );

    assign load_ok = !st_q.valid || msg_ready_i;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        take     = '0;
        if (st_q.valid && msg_ready_i) st_d.valid = 1'b0;
        if (load_ok && found) begin
            take = NUM_PINS'(1) << idx;
            if (res_err) begin
                st_d.err = 1'b1;
            end else if (res_targets != '0) begin
                st_d.valid        = 1'b1;
                st_d.hdr.vector   = (e_dmode == DM_EXTINT) ? legacy_vec_i : e_vector;
                st_d.hdr.dmode    = e_dmode;
                st_d.hdr.logical  = e_logical;
                st_d.hdr.level    = rte_polarity_i[idx];
                st_d.hdr.trigger  = rte_trigger_i[idx];
                st_d.targets      = res_targets;
                if (res_rotate) st_d.rot = st_q.rot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_valid_o   = st_q.valid;
    assign msg_vector_o  = st_q.hdr.vector;
    assign msg_dmode_o   = st_q.hdr.dmode;
    assign msg_logical_o = st_q.hdr.logical;
    assign msg_level_o   = st_q.hdr.level;
    assign msg_trigger_o = st_q.hdr.trigger;
    assign msg_targets_o = st_q.targets;
    assign lowpri_err_o  = st_q.err;

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
    import irqd_pkg::*;
#(
    parameter int NUM_CPUS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid_i,
    input logic                msg_ready_i,
    input logic [7:0]          msg_vector_i,
    input logic [2:0]          msg_dmode_i,
    input logic                msg_logical_i,
    input logic [NUM_CPUS-1:0] msg_targets_i,
    input logic [7:0]          legacy_vec_i
);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_i && !msg_ready_i |=> msg_valid_i && $stable(msg_vector_i)
                                        && $stable(msg_targets_i) && $stable(msg_dmode_i));

    assert_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_i |-> msg_targets_i != '0);

    assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_i && msg_dmode_i == DM_LOWPRI |-> $countones(msg_targets_i) == 1);

    assert_no_phys_lp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_i && msg_dmode_i == DM_LOWPRI |-> msg_logical_i);

    assert_ext_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid_i) && msg_dmode_i == DM_EXTINT |-> msg_vector_i == $past(legacy_vec_i));

endmodule

bind irq_dispatch irq_dispatch_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msg_valid_i   (msg_valid_o),
    .msg_ready_i   (msg_ready_i),
    .msg_vector_i  (msg_vector_o),
    .msg_dmode_i   (msg_dmode_o),
    .msg_logical_i (msg_logical_o),
    .msg_targets_i (msg_targets_o),
    .legacy_vec_i  (legacy_vec_i)
);

// File: tb/irq_dispatch_test.sv
`timescale 1ns/1ps
module irq_dispatch_test;

    localparam int NP = 8;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] msk = '0;
    logic [NP*8-1:0] vec = '0;
    logic [NP*3-1:0] dm = '0;
    logic [NP-1:0] lgc = '0;
    logic [NP-1:0] pol = '0;
    logic [NP-1:0] trg = '0;
    logic [NP*8-1:0] dst = '0;
    logic [7:0]    legacy = 8'hA7;
    logic [NC*8-1:0] ldr;
    logic          ready = 1'b0;

    logic          v_o, lv_o, tr_o, lg_o, err_o;
    logic [7:0]    vec_o;
    logic [2:0]    dm_o;
    logic [NC-1:0] tg_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_dispatch #(.NUM_PINS(NP), .NUM_CPUS(NC), .ROT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .rte_mask_i(msk),
        .rte_vector_i(vec), .rte_dmode_i(dm), .rte_logical_i(lgc),
        .rte_polarity_i(pol), .rte_trigger_i(trg), .rte_dest_i(dst),
        .legacy_vec_i(legacy), .cpu_ldr_i(ldr),
        .msg_valid_o(v_o), .msg_ready_i(ready), .msg_vector_o(vec_o),
        .msg_dmode_o(dm_o), .msg_logical_o(lg_o), .msg_level_o(lv_o),
        .msg_trigger_o(tr_o), .msg_targets_o(tg_o), .lowpri_err_o(err_o)
    );

    // cpu i answers to logical bit i; cpu6 answers to nothing, cpu7 to 0x81
    initial begin
        for (int i = 0; i < NC; i++) ldr[i*8 +: 8] = 8'h01 << i;
        ldr[6*8 +: 8] = 8'h00;
        ldr[7*8 +: 8] = 8'h81;
    end

    task automatic set_ent(int p, logic m, logic [7:0] v, logic [2:0] d,
                           logic l, logic pl, logic t, logic [7:0] de);
        msk[p] = m; vec[p*8 +: 8] = v; dm[p*3 +: 3] = d;
        lgc[p] = l; pol[p] = pl; trg[p] = t; dst[p*8 +: 8] = de;
    endtask

    // raise a pin and land on the negedge where a message is expected
    task automatic fire(int p);
        @(negedge clk) pins[p] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drop(int p);
        @(negedge clk) pins[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic accept();
        ready = 1'b1;
        @(posedge clk);
        #1 ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_msg(string req, logic [7:0] ev, logic [2:0] ed, logic el,
                             logic elv, logic et, logic [NC-1:0] etg);
        logic [22:0] act, exp;
        act = {v_o, vec_o, dm_o, lg_o, lv_o, tr_o, tg_o};
        exp = {1'b1, ev, ed, el, elv, et, etg};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: msg actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(string req);
        logic bad = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (v_o !== 1'b0 || err_o !== 1'b0) bad = 1'b1;
            @(negedge clk);
        end
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s: activity actual valid=%b err=%b expected none", req, v_o, err_o);
        end
    endtask

    task automatic t_reset();
        checks++;
        if ({v_o, err_o, tg_o} !== '0) begin
            fails++;
            $display("FAIL R12 reset: actual=%h expected=0", {v_o, err_o, tg_o});
        end
    endtask

    task automatic t_physical();
        set_ent(0, 0, 8'h31, 3'b000, 0, 1, 0, 8'd2);
        fire(0);
        check_msg("R4 R6 R12 physical single", 8'h31, 3'b000, 0, 1, 0, 8'h04);
        accept(); drop(0);
        set_ent(1, 0, 8'h42, 3'b000, 0, 0, 1, 8'hFF);
        fire(1);
        check_msg("R5 broadcast", 8'h42, 3'b000, 0, 0, 1, 8'hFF);
        accept(); drop(1);
        set_ent(1, 0, 8'h42, 3'b000, 0, 0, 1, 8'd9);
        fire(1);
        check_idle("R6 out of range id");
        drop(1);
    endtask

    task automatic t_edge();
        set_ent(0, 0, 8'h10, 3'b000, 0, 0, 0, 8'd1);
        fire(0);
        check_msg("R1 first rise", 8'h10, 3'b000, 0, 0, 0, 8'h02);
        accept();
        check_idle("R1 held high");
        drop(0);
        fire(0);
        check_msg("R1 rise after lower", 8'h10, 3'b000, 0, 0, 0, 8'h02);
        accept(); drop(0);
    endtask

    task automatic t_mask();
        set_ent(7, 1, 8'h77, 3'b000, 0, 0, 0, 8'd0);
        fire(7);
        check_idle("R2 masked rise");
        msk[7] = 1'b0;
        check_idle("R2 unmask while high");
        drop(7);
        fire(7);
        check_msg("R2 unmasked rise", 8'h77, 3'b000, 0, 0, 0, 8'h01);
        accept(); drop(7);
    endtask

    task automatic t_extint();
        set_ent(3, 0, 8'h55, 3'b111, 0, 1, 1, 8'd5);
        legacy = 8'hA7;
        fire(3);
        check_msg("R3 external vector", 8'hA7, 3'b111, 0, 1, 1, 8'h20);
        accept(); drop(3);
    endtask

    task automatic t_logical();
        set_ent(4, 0, 8'h60, 3'b000, 1, 0, 1, 8'h06);
        fire(4);
        check_msg("R8 logical two cpus", 8'h60, 3'b000, 1, 0, 1, 8'h06);
        accept(); drop(4);
        set_ent(4, 0, 8'h61, 3'b000, 1, 0, 0, 8'h01);
        fire(4);
        check_msg("R8 logical shared bit", 8'h61, 3'b000, 1, 0, 0, 8'h81);
        accept(); drop(4);
    endtask

    // dest 0x0B matches cpus 0,1,3,7 -> walk through them by counter
    task automatic t_lowpri();
        logic [7:0] order [4] = '{8'h01, 8'h02, 8'h08, 8'h80};
        set_ent(4, 0, 8'h70, 3'b001, 1, 0, 0, 8'h0B);
        for (int n = 0; n < 5; n++) begin
            fire(4);
            check_msg("R9 rotation", 8'h70, 3'b001, 1, 0, 0, order[n % 4]);
            accept(); drop(4);
        end
        set_ent(4, 0, 8'h70, 3'b001, 1, 0, 0, 8'h40);
        fire(4);
        check_idle("R10 empty logical set");
        drop(4);
        set_ent(4, 0, 8'h70, 3'b001, 1, 0, 0, 8'h0B);
        fire(4);
        check_msg("R10 counter unchanged", 8'h70, 3'b001, 1, 0, 0, 8'h02);
        accept(); drop(4);
    endtask

    task automatic t_lp_phys();
        set_ent(5, 0, 8'h80, 3'b001, 0, 0, 0, 8'd1);
        fire(5);
        checks++;
        if ({err_o, v_o} !== 2'b10) begin
            fails++;
            $display("FAIL R7 error pulse: actual=%b expected=10", {err_o, v_o});
        end
        @(negedge clk);
        checks++;
        if ({err_o, v_o} !== 2'b00) begin
            fails++;
            $display("FAIL R7 pulse length: actual=%b expected=00", {err_o, v_o});
        end
        drop(5);
    endtask

    task automatic t_simul();
        set_ent(2, 0, 8'h22, 3'b000, 0, 0, 0, 8'd1);
        set_ent(6, 0, 8'h66, 3'b000, 0, 1, 0, 8'd3);
        @(negedge clk) begin pins[2] = 1'b1; pins[6] = 1'b1; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_msg("R11 lowest index first", 8'h22, 3'b000, 0, 0, 0, 8'h02);
        repeat (4) @(negedge clk);
        check_msg("R12 held while not ready", 8'h22, 3'b000, 0, 0, 0, 8'h02);
        accept();
        check_msg("R11 second pending", 8'h66, 3'b000, 0, 1, 0, 8'h08);
        accept();
        check_idle("R11 queue drained");
        pins[2] = 1'b0; pins[6] = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_physical();
        t_edge();
        t_mask();
        t_extint();
        t_logical();
        t_lowpri();
        t_lp_phys();
        t_simul();
        finish_run();
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule